// File: doc/BRIEF.md
# Dual-Die Status Selector

Two flash dies share one command/address/data bus, and each may be busy with its own operation (one erasing while the other reads, for instance). This block watches the command bytes and row addresses latched from that bus and decides which die's status the host sees. Two dedicated opcodes pick a die directly. The generic status opcode reports the die named by the most recently latched row address. The status byte is then built live from the chosen die's ready, array-ready and fail flags together with the write-protect pin.

The row address space is split in two equal halves. The lower half belongs to the first die and the upper half to the second. With the default 19-bit row address the split falls at 40000h.

The ready/busy outputs of the dies are modelled as an open-drain wired-AND, so the combined line is low while either die is busy. After an identification read the generic status opcode has no effect until a 00h command has been issued. Internal program and erase sequencing lives elsewhere.

Top module: `dual_die_status`

## Requirements
- R1: After reset, status_oe is 0, status_byte is 00h, and the remembered die is the first one.
- R2: Command F2h places the first die's status on status_byte and raises status_oe, starting the cycle after the command is latched.
- R3: Command F3h places the second die's status on status_byte and raises status_oe, starting the cycle after the command is latched.
- R4: Command 70h shows the status of the die named by the last latched row address. Addresses below 2^(ROW_W-1) name the first die and the rest name the second. With no address latched since reset, the first die is used.
- R5: The status byte has write-protect (wp_n) in bit 7, ready (not die_busy) in bit 6, array ready (not die_array_busy) in bit 5 and fail in bit 0. Bits 4 to 1 are 0. While status_oe is 0, status_byte is 00h.
- R6: While a die is selected, status_byte follows that die's flags combinationally and ignores the other die's flags.
- R7: rb_n is 0 whenever either die is busy and 1 only when both are ready.
- R8: After command 90h, a 70h command leaves status_oe at 0. Once a 00h command has been latched, 70h works again.
- R9: Any command other than F2h, F3h or 70h drops status_oe to 0 and status_byte to 00h on the next cycle.
- R10: A row address latched while status is shown does not change the die being shown. It only affects a later 70h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command byte is latched this cycle |
| cmd_byte | input | 8 | Latched command byte |
| addr_valid | input | 1 | A full row address is latched this cycle |
| row_addr | input | ROW_W | Latched row address |
| die_busy | input | 2 | Per-die busy flag (bit 0 = first die) |
| die_array_busy | input | 2 | Per-die array busy flag |
| die_fail | input | 2 | Per-die fail flag of the last operation |
| wp_n | input | 1 | Write-protect pin, 1 = not protected |
| status_byte | output | 8 | Status byte for the bus, 00h when not in status mode |
| status_oe | output | 1 | Status byte is driven onto the bus |
| rb_n | output | 1 | Combined ready/busy, low while any die is busy |

## Verification
The bench builds the block with ROW_W = 6, so the row address space holds only 64 values. It can therefore latch every row address, follow each one with a 70h command and check the die split on both sides of the boundary at 32. At each die selection it also steps through all 128 combinations of the two dies' busy, array-busy and fail flags and the write-protect pin. This covers the full status encoding, the isolation from the non-selected die and the wired ready/busy line.

// File: rtl/dual_die_status.sv
module dual_die_status #(
  parameter int ROW_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             addr_valid,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [1:0]       die_busy,
  input  logic [1:0]       die_array_busy,
  input  logic [1:0]       die_fail,
  input  logic             wp_n,
  output logic [7:0]       status_byte,
  output logic             status_oe,
  output logic             rb_n
);
  localparam logic [ROW_W-1:0] SECOND_BASE = {1'b1, {(ROW_W-1){1'b0}}};
  localparam logic [7:0] OP_SEL0 = 8'hF2;
  localparam logic [7:0] OP_SEL1 = 8'hF3;
  localparam logic [7:0] OP_STAT = 8'h70;
  localparam logic [7:0] OP_IDENT = 8'h90;

  typedef enum logic [1:0] {M_IDLE, M_STAT, M_IDENT} mode_t;

  mode_t mode_q;
  logic  sel_q;
  logic  last_die_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= M_IDLE;
      sel_q      <= 1'b0;
      last_die_q <= 1'b0;
    end else begin
      if (addr_valid) last_die_q <= (row_addr >= SECOND_BASE);
      if (cmd_valid) begin
        case (cmd_byte)
          OP_SEL0: begin
            mode_q <= M_STAT;
            sel_q  <= 1'b0;
          end
          OP_SEL1: begin
            mode_q <= M_STAT;
            sel_q  <= 1'b1;
          end
          OP_STAT: begin
            if (mode_q != M_IDENT) begin
              mode_q <= M_STAT;
              sel_q  <= last_die_q;
            end
          end
          OP_IDENT: mode_q <= M_IDENT;
          default:  mode_q <= M_IDLE;
        endcase
      end
    end
  end

  assign status_oe   = (mode_q == M_STAT);
  assign status_byte = status_oe ? {wp_n, ~die_busy[sel_q], ~die_array_busy[sel_q],
                                    4'b0000, die_fail[sel_q]} : 8'h00;
  assign rb_n        = ~|die_busy;
endmodule

// File: rtl/dual_die_status_chk.sv
module dual_die_status_chk #(
  parameter int ROW_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [7:0]       cmd_byte,
  input logic             addr_valid,
  input logic [ROW_W-1:0] row_addr,
  input logic [1:0]       die_busy,
  input logic [1:0]       die_array_busy,
  input logic [1:0]       die_fail,
  input logic             wp_n,
  input logic [7:0]       status_byte,
  input logic             status_oe,
  input logic             rb_n
);
  assert_rb_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (die_busy != 2'b00) |-> !rb_n);

  assert_rb_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rb_n |-> (die_busy == 2'b00));

  assert_sel_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'hF2) |=>
      (status_oe && status_byte[6] == !die_busy[0] && status_byte[0] == die_fail[0]));

  assert_sel_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'hF3) |=>
      (status_oe && status_byte[5] == !die_array_busy[1] && status_byte[0] == die_fail[1]));

  assert_ident_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h90) |=> !status_oe);

  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !status_oe |-> (status_byte == 8'h00));

  assert_zero_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[4:1] == 4'b0000);

  assert_other_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte != 8'hF2 && cmd_byte != 8'hF3 && cmd_byte != 8'h70) |=> !status_oe);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_oe && !cmd_valid) |=> status_oe);
endmodule

bind dual_die_status dual_die_status_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/dual_die_status_bench.sv
module dual_die_status_bench;
  localparam int ROW_W = 6;
  localparam int HALF  = 1 << (ROW_W - 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [7:0]       cmd_byte = 8'h00;
  logic             addr_valid = 1'b0;
  logic [ROW_W-1:0] row_addr = '0;
  logic [1:0]       die_busy = 2'b00;
  logic [1:0]       die_array_busy = 2'b00;
  logic [1:0]       die_fail = 2'b00;
  logic             wp_n = 1'b1;
  logic [7:0]       status_byte;
  logic             status_oe;
  logic             rb_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_die_status #(.ROW_W(ROW_W)) u_dual_die_status (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .addr_valid(addr_valid), .row_addr(row_addr), .die_busy(die_busy),
    .die_array_busy(die_array_busy), .die_fail(die_fail), .wp_n(wp_n),
    .status_byte(status_byte), .status_oe(status_oe), .rb_n(rb_n)
  );

  function automatic logic [7:0] expect_byte(int die);
    return {wp_n, ~die_busy[die], ~die_array_busy[die], 4'b0000, die_fail[die]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send_cmd(logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
  endtask

  task automatic send_addr(int a);
    @(negedge clk);
    addr_valid = 1'b1;
    row_addr   = ROW_W'(a);
    @(negedge clk);
    addr_valid = 1'b0;
    #1;
  endtask

  task automatic set_flags(int p);
    die_busy       = p[1:0];
    die_array_busy = p[3:2];
    die_fail       = p[5:4];
    wp_n           = p[6];
    #1;
  endtask

  task automatic sweep_die(int die, string req);
    for (int p = 0; p < 128; p++) begin
      set_flags(p);
      chk(req, {7'b0, status_oe}, 8'h01);
      chk(req, status_byte, expect_byte(die));
      chk("R7", {7'b0, rb_n}, {7'b0, (p[1:0] == 2'b00)});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", {7'b0, status_oe}, 8'h00);
    chk("R1", status_byte, 8'h00);

    // R4: default die after reset is the first one
    set_flags(8'h21);
    send_cmd(8'h70);
    chk("R4", status_byte, expect_byte(0));

    // R2, R3, R5, R6: full flag sweep on each selected die
    send_cmd(8'hF2);
    sweep_die(0, "R2");
    send_cmd(8'hF3);
    sweep_die(1, "R3");

    // R4: every row address followed by 70h
    set_flags(7'b1010001 | (1 << 6));
    for (int a = 0; a < (1 << ROW_W); a++) begin
      send_addr(a);
      send_cmd(8'h70);
      chk("R4", {7'b0, status_oe}, 8'h01);
      chk("R4", status_byte, expect_byte((a >= HALF) ? 1 : 0));
    end

    // R10: address while showing status does not move selection
    send_cmd(8'hF3);
    send_addr(0);
    chk("R10", status_byte, expect_byte(1));
    send_cmd(8'h70);
    chk("R10", status_byte, expect_byte(0));
    send_addr(HALF);
    chk("R10", status_byte, expect_byte(0));

    // R8: identification read blocks 70h until 00h
    send_cmd(8'h90);
    chk("R8", {7'b0, status_oe}, 8'h00);
    send_cmd(8'h70);
    chk("R8", {7'b0, status_oe}, 8'h00);
    chk("R8", status_byte, 8'h00);
    send_cmd(8'h00);
    send_cmd(8'h70);
    chk("R8", {7'b0, status_oe}, 8'h01);
    chk("R8", status_byte, expect_byte(1));

    // R9: other commands end status output
    send_cmd(8'hF2);
    send_cmd(8'h80);
    chk("R9", {7'b0, status_oe}, 8'h00);
    chk("R9", status_byte, 8'h00);
    send_cmd(8'hF3);
    send_cmd(8'h60);
    chk("R9", {7'b0, status_oe}, 8'h00);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule